// File: doc/BRIEF.md
# 100BASE-X Receive Symbol Decoder

This block sits after the descrambler in a 100BASE-X receive path. Each clock it takes one aligned 5-bit code group and turns the stream into MII receive signals: a data nibble, a data-valid flag, an error flag and a carrier-sense flag. A small state machine tracks carrier. It recognises the start-of-stream pair and the end-of-stream pair. It flags invalid code groups inside a frame, and it notices when a stream ends early on idle. When carrier starts with anything other than a proper start pair, the decoder raises a false-carrier report. That report can be turned off, and it keeps the event quiet until the line has been idle for a while.

Three static controls change how the block behaves. One enables or disables the false-carrier report. One skips the 5B-to-4B decoding, so the raw code groups appear on the 5-bit receive bus and the frame timing still follows the delimiters. One skips symbol alignment, which also removes carrier detection: the block then only copies raw symbols to its output.

Each symbol is first held in a one-symbol lookahead register, so the decoder can judge the start and end pairs before it emits the first of the two. A symbol sampled at rising edge n affects the outputs registered at edge n+1.

Top module: `rx100Decoder`

## Requirements
- R1: While reset is asserted, and until the first symbol has been handled, rxDv, rxEr and crs are 0 and rxData is 00000.
- R2: Inside a frame with decoding active, each data code group maps to its 4-bit nibble on rxData[3:0]. The mapping is: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101. For such a group rxDv=1 and rxEr=0. rxData[4] is 0 whenever decoding is active, and rxDv=1 always comes with crs=1.
- R3: From idle, the code group 11000 followed directly by 10001 opens a frame. Each of these two symbols is emitted as nibble 0101 with rxDv=1, rxEr=0 and crs=1. rxDv never rises at any other point.
- R4: Any other non-idle symbol seen in the idle state is a false carrier. This includes 11000 followed by anything except 10001. With the report enabled and decoding active, each symbol of the event shows rxDv=0, rxEr=1 and rxData=01110, with crs=1.
- R5: A false carrier continues until an idle symbol (11111) is followed by a second idle. That first idle is emitted quiet, and carrier ends.
- R6: With the report disabled (badSsdEn=0), a false carrier gives rxDv=0 and rxEr=0. rxData is 00000, or the raw symbol when decoding is bypassed, and crs stays 1.
- R7: With decoding bypassed, a reported false carrier gives rxDv=0, rxEr=0 and rxData=11110.
- R8: With decoding bypassed, every other emission puts the raw code group on rxData. rxDv and crs follow the same framing as in decoded mode, and rxEr stays 0.
- R9: With alignment bypassed, rxDv, rxEr and crs stay 0 and rxData is the raw symbol. No frame and no false carrier is ever detected.
- R10: Inside a frame, 01101 followed by 10111-free 00111 ends the frame. Both symbols give rxDv=0 with crs=1, and the block returns to idle.
- R11: An idle symbol inside a frame is a premature end. It gives rxDv=1, rxEr=1 and rxData=00000, and the block returns to idle.
- R12: Any other code group inside a frame is a code error. This covers non-data groups and 01101 not followed by 00111. It gives rxDv=1, rxEr=1 and rxData=00000, and the frame continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rstN | input | 1 | Active-low synchronous reset |
| symIn | input | 5 | Aligned code group from the descrambler |
| badSsdEn | input | 1 | Enables the false-carrier report |
| bypassDecode | input | 1 | Skip 5B-to-4B decoding; raw groups on rxData |
| bypassAlign | input | 1 | Skip alignment and carrier detection |
| rxData | output | 5 | Receive nibble in bits [3:0], or raw code group |
| rxDv | output | 1 | Receive data valid |
| rxEr | output | 1 | Receive error |
| crs | output | 1 | Carrier sense |

## Verification
The assertions assume that the three mode controls are sampled together with the symbol stream. They also assume that a change to a mode first affects the outputs one edge later. For this reason every mode-dependent property looks at the control's value one cycle in the past. The frame-start property relies on the stream reaching the block with no gaps, one symbol per clock. The bench changes modes only at the falling edge, between symbols, and never skips a cycle. Random code groups are allowed to contain all 32 values, so any sequence of symbols is legal input, and the properties must hold for each of them.

// File: rtl/rxDecPkg.sv
package rxDecPkg;
  localparam int SYM_W = 5;
  localparam int NIB_W = 4;

  localparam logic [SYM_W-1:0] SYM_IDLE     = 5'b11111;
  localparam logic [SYM_W-1:0] SYM_J        = 5'b11000;
  localparam logic [SYM_W-1:0] SYM_K        = 5'b10001;
  localparam logic [SYM_W-1:0] SYM_T        = 5'b01101;
  localparam logic [SYM_W-1:0] SYM_R        = 5'b00111;
  localparam logic [SYM_W-1:0] SYM_FCAR_RAW = 5'b11110;
  localparam logic [NIB_W-1:0] NIB_PRE      = 4'b0101;
  localparam logic [NIB_W-1:0] NIB_FCAR     = 4'b1110;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SSDK, ST_FRAME, ST_END, ST_FCAR
  } rxStateE;

  typedef enum logic [2:0] {
    EM_QUIET, EM_PRE, EM_DATA, EM_CODEERR, EM_PREMEND, EM_FCAR, EM_RAW
  } emitE;

  typedef struct packed {
    emitE emit;
    logic carrier;
  } ctlStrobeT;

  typedef struct packed {
    logic isIdle;
    logic isJ;
    logic isK;
    logic isT;
    logic isR;
    logic isData;
  } symClassT;

  // Returns {valid, nibble}; valid is 0 for any non-data code group.
  function automatic logic [NIB_W:0] decodeGroup(input logic [SYM_W-1:0] g);
    logic [NIB_W:0] r;
    case (g)
      5'b11110: r = {1'b1, 4'h0};
      5'b01001: r = {1'b1, 4'h1};
      5'b10100: r = {1'b1, 4'h2};
      5'b10101: r = {1'b1, 4'h3};
      5'b01010: r = {1'b1, 4'h4};
      5'b01011: r = {1'b1, 4'h5};
      5'b01110: r = {1'b1, 4'h6};
      5'b01111: r = {1'b1, 4'h7};
      5'b10010: r = {1'b1, 4'h8};
      5'b10011: r = {1'b1, 4'h9};
      5'b10110: r = {1'b1, 4'hA};
      5'b10111: r = {1'b1, 4'hB};
      5'b11010: r = {1'b1, 4'hC};
      5'b11011: r = {1'b1, 4'hD};
      5'b11100: r = {1'b1, 4'hE};
      5'b11101: r = {1'b1, 4'hF};
      default:  r = '0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/rxSymDp.sv
module rxSymDp
  import rxDecPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [SYM_W-1:0] symIn,
  input  logic             bypassDecode,
  input  logic             badSsdEn,
  input  ctlStrobeT        strobe,
  output symClassT         heldCls,
  output symClassT         curCls,
  output logic [SYM_W-1:0] rxData,
  output logic             rxDv,
  output logic             rxEr,
  output logic             crs
);
  localparam int TAPS = 2;

  logic [SYM_W-1:0] heldSym;
  logic [SYM_W-1:0] tap [TAPS];
  symClassT         cls [TAPS];
  logic [NIB_W:0]   heldDec;
  logic [SYM_W-1:0] dataN;
  logic             dvN;
  logic             erN;

  // Lookahead register: the symbol being emitted waits one clock.
  always_ff @(posedge clk) begin
    if (!rstN) heldSym <= SYM_IDLE;
    else       heldSym <= symIn;
  end

  assign tap[0] = heldSym;
  assign tap[1] = symIn;

  for (genvar i = 0; i < TAPS; i++) begin : g_cls
    logic [NIB_W:0] dec;
    assign dec    = decodeGroup(tap[i]);
    assign cls[i] = '{isIdle: (tap[i] == SYM_IDLE),
                      isJ:    (tap[i] == SYM_J),
                      isK:    (tap[i] == SYM_K),
                      isT:    (tap[i] == SYM_T),
                      isR:    (tap[i] == SYM_R),
                      isData: dec[NIB_W]};
  end

  assign heldCls = cls[0];
  assign curCls  = cls[1];
  assign heldDec = decodeGroup(heldSym);

  always_comb begin
    dvN   = 1'b0;
    erN   = 1'b0;
    dataN = '0;
    unique case (strobe.emit)
      EM_QUIET: dataN = bypassDecode ? heldSym : '0;
      EM_PRE: begin
        dvN   = 1'b1;
        dataN = bypassDecode ? heldSym : {1'b0, NIB_PRE};
      end
      EM_DATA: begin
        dvN   = 1'b1;
        dataN = bypassDecode ? heldSym : {1'b0, heldDec[NIB_W-1:0]};
      end
      EM_CODEERR, EM_PREMEND: begin
        dvN   = 1'b1;
        erN   = !bypassDecode;
        dataN = bypassDecode ? heldSym : '0;
      end
      EM_FCAR: begin
        if (!badSsdEn) begin
          dataN = bypassDecode ? heldSym : '0;
        end else if (bypassDecode) begin
          dataN = SYM_FCAR_RAW;
        end else begin
          erN   = 1'b1;
          dataN = {1'b0, NIB_FCAR};
        end
      end
      EM_RAW:  dataN = heldSym;
      default: dataN = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData <= '0;
      rxDv   <= 1'b0;
      rxEr   <= 1'b0;
      crs    <= 1'b0;
    end else begin
      rxData <= dataN;
      rxDv   <= dvN;
      rxEr   <= erN;
      crs    <= strobe.carrier;
    end
  end
endmodule

// File: rtl/rxSymCtl.sv
module rxSymCtl
  import rxDecPkg::*;
#(
  parameter int IDLE_RUN = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      bypassAlign,
  input  symClassT  heldCls,
  input  symClassT  curCls,
  output ctlStrobeT strobe
);
  localparam int CNT_W = (IDLE_RUN < 2) ? 1 : $clog2(IDLE_RUN);
  localparam logic [CNT_W-1:0] EXIT_AT = CNT_W'(IDLE_RUN - 2);

  rxStateE          state;
  rxStateE          stNext;
  logic [CNT_W-1:0] idleCnt;
  logic             fcarExit;
  emitE             emitN;
  logic             carrierN;

  // The held idle plus the lookahead idle complete the run.
  assign fcarExit = heldCls.isIdle && curCls.isIdle && (idleCnt == EXIT_AT);

  always_comb begin
    stNext   = state;
    emitN    = EM_QUIET;
    carrierN = 1'b1;
    if (bypassAlign) begin
      stNext   = ST_IDLE;
      emitN    = EM_RAW;
      carrierN = 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (heldCls.isIdle) begin
            carrierN = 1'b0;
          end else if (heldCls.isJ && curCls.isK) begin
            emitN  = EM_PRE;
            stNext = ST_SSDK;
          end else begin
            emitN  = EM_FCAR;
            stNext = ST_FCAR;
          end
        end
        ST_SSDK: begin
          emitN  = EM_PRE;
          stNext = ST_FRAME;
        end
        ST_FRAME: begin
          if (heldCls.isT && curCls.isR) begin
            stNext = ST_END;
          end else if (heldCls.isIdle) begin
            emitN  = EM_PREMEND;
            stNext = ST_IDLE;
          end else if (heldCls.isData) begin
            emitN = EM_DATA;
          end else begin
            emitN = EM_CODEERR;
          end
        end
        ST_END: stNext = ST_IDLE;
        ST_FCAR: begin
          if (fcarExit) begin
            carrierN = 1'b0;
            stNext   = ST_IDLE;
          end else begin
            emitN = EM_FCAR;
          end
        end
        default: stNext = ST_IDLE;
      endcase
    end
  end

  assign strobe = '{emit: emitN, carrier: carrierN};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      idleCnt <= '0;
    end else begin
      state <= stNext;
      if (state == ST_FCAR && heldCls.isIdle && !bypassAlign) begin
        if (idleCnt != EXIT_AT) idleCnt <= idleCnt + 1'b1;
      end else begin
        idleCnt <= '0;
      end
    end
  end
endmodule

// File: rtl/rx100Decoder.sv
module rx100Decoder
  import rxDecPkg::*;
#(
  parameter int IDLE_RUN = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SYM_W-1:0] symIn,
  input  logic             badSsdEn,
  input  logic             bypassDecode,
  input  logic             bypassAlign,
  output logic [SYM_W-1:0] rxData,
  output logic             rxDv,
  output logic             rxEr,
  output logic             crs
);
  symClassT  heldCls;
  symClassT  curCls;
  ctlStrobeT strobe;

  rxSymCtl #(.IDLE_RUN(IDLE_RUN)) u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .bypassAlign (bypassAlign),
    .heldCls     (heldCls),
    .curCls      (curCls),
    .strobe      (strobe)
  );

  rxSymDp u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .symIn        (symIn),
    .bypassDecode (bypassDecode),
    .badSsdEn     (badSsdEn),
    .strobe       (strobe),
    .heldCls      (heldCls),
    .curCls       (curCls),
    .rxData       (rxData),
    .rxDv         (rxDv),
    .rxEr         (rxEr),
    .crs          (crs)
  );
endmodule

// File: rtl/rxDecChk.sv
module rxDecChk (
  input logic       clk,
  input logic       rstN,
  input logic [4:0] symIn,
  input logic       badSsdEn,
  input logic       bypassDecode,
  input logic       bypassAlign,
  input logic [4:0] rxData,
  input logic       rxDv,
  input logic       rxEr,
  input logic       crs
);
  AST_DV_HAS_CRS: assert property (@(posedge clk) disable iff (!rstN)
    rxDv |-> crs); // R2

  AST_NIBBLE_TOP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(bypassDecode) && !$past(bypassAlign)) |-> !rxData[4]); // R2

  AST_DV_RISE_ON_JK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxDv) |-> ($past(symIn, 2) == 5'b11000 && $past(symIn) == 5'b10001)); // R3

  AST_FCAR_CODE: assert property (@(posedge clk) disable iff (!rstN)
    (rxEr && !rxDv) |-> (rxData == 5'b01110 && $past(badSsdEn) && !$past(bypassDecode))); // R4

  AST_FCAR_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(badSsdEn) && !rxDv) |-> !rxEr); // R6

  AST_BYPASS_NO_ER: assert property (@(posedge clk) disable iff (!rstN)
    $past(bypassDecode) |-> !rxEr); // R8

  AST_ALIGN_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $past(bypassAlign) |-> (!rxDv && !rxEr && !crs)); // R9

  AST_ERR_NIBBLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rxDv && rxEr) |-> (rxData == 5'b00000)); // R12
endmodule

bind rx100Decoder rxDecChk u_chk (.*);

// File: tb/tb_rx100Decoder.sv
module tb_rx100Decoder;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] symIn = 5'b11111;
  logic       badSsdEn = 1'b1;
  logic       bypassDecode = 1'b0;
  logic       bypassAlign = 1'b0;
  logic [4:0] rxData;
  logic       rxDv;
  logic       rxEr;
  logic       crs;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  rx100Decoder dut (
    .clk(clk), .rstN(rstN), .symIn(symIn), .badSsdEn(badSsdEn),
    .bypassDecode(bypassDecode), .bypassAlign(bypassAlign),
    .rxData(rxData), .rxDv(rxDv), .rxEr(rxEr), .crs(crs)
  );

  always #5 clk = ~clk;

  localparam logic [4:0] C_IDLE = 5'b11111, C_J = 5'b11000, C_K = 5'b10001,
                         C_T = 5'b01101, C_R = 5'b00111;
  logic [4:0] codeOf [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                              5'b01010, 5'b01011, 5'b01110, 5'b01111,
                              5'b10010, 5'b10011, 5'b10110, 5'b10111,
                              5'b11010, 5'b11011, 5'b11100, 5'b11101};

  // Reference model state: 0 idle, 1 after J, 2 frame, 3 after T, 4 false carrier
  int         mState = 0;
  logic [4:0] lastSym = C_IDLE;

  function automatic int nibbleOf(input logic [4:0] c);
    for (int n = 0; n < 16; n++) if (codeOf[n] == c) return n;
    return -1;
  endfunction

  task automatic report(input string tag, input logic [4:0] eD, input logic eV,
                        input logic eE, input logic eC);
    checks++;
    if (rxData !== eD || rxDv !== eV || rxEr !== eE || crs !== eC) begin
      errors++;
      $display("FAIL %s: got data=%b dv=%b er=%b crs=%b, expected data=%b dv=%b er=%b crs=%b",
               tag, rxData, rxDv, rxEr, crs, eD, eV, eE, eC);
    end
  endtask

  task automatic step(input logic [4:0] s);
    logic [4:0] eD;
    logic       eV, eE, eC;
    string      tag;
    int         nib;
    symIn = s;
    @(posedge clk);
    @(negedge clk);
    eD = 5'b00000; eV = 1'b0; eE = 1'b0; eC = 1'b1;
    nib = nibbleOf(lastSym);
    if (bypassAlign) begin
      eD = lastSym; eC = 1'b0; tag = "R9 align bypass"; mState = 0;
    end else begin
      case (mState)
        0: begin
          if (lastSym == C_IDLE) begin
            eC = 1'b0; tag = "R2 idle";
          end else if (lastSym == C_J && s == C_K) begin
            eV = 1'b1; eD = 5'b00101; tag = "R3 start pair J"; mState = 1;
          end else begin
            tag = "R4 false carrier"; mState = 4;
          end
        end
        1: begin eV = 1'b1; eD = 5'b00101; tag = "R3 start pair K"; mState = 2; end
        2: begin
          if (lastSym == C_T && s == C_R) begin
            tag = "R10 end pair T"; mState = 3;
          end else if (lastSym == C_IDLE) begin
            eV = 1'b1; eE = 1'b1; tag = "R11 premature end"; mState = 0;
          end else if (nib >= 0) begin
            eV = 1'b1; eD = 5'(nib); tag = "R2 data nibble";
          end else begin
            eV = 1'b1; eE = 1'b1; tag = "R12 code error";
          end
        end
        3: begin tag = "R10 end pair R"; mState = 0; end
        default: begin
          if (lastSym == C_IDLE && s == C_IDLE) begin
            eC = 1'b0; tag = "R5 false carrier exit"; mState = 0;
          end else begin
            tag = "R5 false carrier held";
          end
        end
      endcase
      // False-carrier report form by mode
      if (mState == 4 && tag != "R5 false carrier exit") begin
        if (!badSsdEn) tag = "R6 report disabled";
        else if (bypassDecode) begin eD = 5'b11110; tag = "R7 bypass false carrier"; end
        else begin eE = 1'b1; eD = 5'b01110; end
      end
      // Raw pass-through when decoding is bypassed
      if (bypassDecode) begin
        eE = 1'b0;
        if (!(mState == 4 && badSsdEn && tag != "R5 false carrier exit")) begin
          eD = lastSym; tag = {"R8 bypass ", tag};
        end
      end
    end
    report(tag, eD, eV, eE, eC);
    lastSym = s;
  endtask

  task automatic idles(input int n);
    for (int i = 0; i < n; i++) step(C_IDLE);
  endtask

  task automatic frame(input int len, input bit injectErr, input bit cleanEnd);
    step(C_J); step(C_K);
    for (int i = 0; i < len; i++) begin
      if (injectErr && i == len / 2) step(5'($urandom % 32));
      else step(codeOf[$urandom % 16]);
    end
    if (cleanEnd) begin step(C_T); step(C_R); end
    else step(C_IDLE);
    idles(3);
  endtask

  task automatic setMode(input bit en, input bit bpd, input bit bpa);
    badSsdEn = en; bypassDecode = bpd; bypassAlign = bpa;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    report("R1 reset", 5'b00000, 1'b0, 1'b0, 1'b0);
    symIn = C_J;
    @(negedge clk);
    report("R1 reset held", 5'b00000, 1'b0, 1'b0, 1'b0);
    symIn = C_IDLE;
    rstN = 1'b1;

    // R1: first emission after reset is quiet
    idles(3);
    // R2, R3, R10: clean frame carrying every nibble
    step(C_J); step(C_K);
    for (int n = 0; n < 16; n++) step(codeOf[n]);
    step(C_T); step(C_R); idles(3);
    // R4, R5: J then a data group; then bare non-J start interrupted by one idle
    step(C_J); step(codeOf[1]); idles(3);
    step(codeOf[6]); step(5'b00000); step(C_IDLE); step(codeOf[3]); idles(3);
    // R4: lone K from idle
    step(C_K); idles(3);
    // R12: code errors inside a frame, T not followed by R
    step(C_J); step(C_K); step(codeOf[5]); step(5'b00000); step(C_K);
    step(C_T); step(codeOf[2]); step(C_T); step(C_R); idles(3);
    // R11: premature end
    step(C_J); step(C_K); step(codeOf[9]); step(codeOf[10]); idles(3);
    // R6: report disabled
    setMode(1'b0, 1'b0, 1'b0);
    step(C_J); step(C_T); step(codeOf[4]); idles(3);
    // R7, R8: decoding bypassed
    setMode(1'b1, 1'b1, 1'b0);
    frame(6, 1'b1, 1'b1);
    step(codeOf[0]); step(C_J); idles(3);
    frame(4, 1'b0, 1'b0);
    setMode(1'b0, 1'b1, 1'b0);
    step(codeOf[7]); idles(3);
    // R9: alignment bypassed
    setMode(1'b1, 1'b0, 1'b1);
    frame(5, 1'b0, 1'b1);
    step(codeOf[3]); idles(2);
    setMode(1'b1, 1'b0, 1'b0);
    idles(3);

    // Constrained random segments
    for (int seg = 0; seg < 300; seg++) begin
      int pick;
      setMode(($urandom % 4) != 0, ($urandom % 5) == 0, ($urandom % 7) == 0);
      idles(2 + $urandom % 3);
      pick = $urandom % 10;
      if (pick < 6) begin
        frame(1 + $urandom % 20, ($urandom % 3) == 0, ($urandom % 5) != 0);
      end else if (pick < 8) begin
        step(C_J);
        step(5'($urandom % 32));
        for (int i = 0; i < int'($urandom % 4); i++) step(5'($urandom % 32));
        idles(3);
      end else begin
        for (int i = 0; i < 1 + int'($urandom % 5); i++) step(5'($urandom % 32));
        idles(3);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule